// File: doc/BRIEF.md
# Banked Multi-Row Hash Store

This block keeps one hash word for each row of a table. The write side stores a single row per clock cycle. The read side returns a whole aligned group of eight consecutive rows in one request. Each lane of the group carries its row number, its stored hash and a flag that says whether the row has been written since reset.

The table is split into eight banks by the low row bits. Row r lives in bank (r mod 8) at bank address (r / 8). An aligned base row therefore selects the same address in every bank, and all eight lanes come out in the same cycle.

A read is registered. The result appears in the cycle after the request is sampled. The result data then holds until the next request.

Top module: `hash_store_banked`

## Requirements
- R1: One read request returns LANES=8 rows at once, namely rows base, base+1, ..., base+7 of the aligned group.
- R2: A read request sampled on clock edge N drives rd_valid_o high for the cycle after edge N. If no request is sampled on edge N+1, rd_valid_o is low again after that edge.
- R3: Lane k of rd_row_ids_o occupies bits [k*ROW_BITS +: ROW_BITS] and equals the aligned base row plus k.
- R4: Lane k of rd_hashes_o occupies bits [k*HASH_BITS +: HASH_BITS] and equals the hash most recently written to that row.
- R5: One write is accepted on every cycle where wr_valid_i is high. Back-to-back writes are all stored, and a later write to the same row replaces the earlier hash.
- R6: Bit k of rd_lane_valid_o is 1 exactly when row base+k has been written since the last reset. The mask is updated together with the read data.
- R7: Row r is stored in bank (r mod 8) at address (r / 8). Rows that share their low three bits but lie in different groups stay independent.
- R8: While rst_ni is low, rd_valid_o and rd_lane_valid_o are 0. Reset also forgets which rows were written, so a read after reset returns an all-zero mask.
- R9: When a write and a read of the same row are sampled on the same edge, the read returns that row's previous hash and previous written flag. A later read returns the new hash.
- R10: The low three bits of rd_base_row_i are ignored. The group is always the one that contains the given row.
- R11: While no read is sampled, rd_row_ids_o, rd_hashes_o and rd_lane_valid_o keep their last values. Writes do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write strobe |
| wr_row_i | input | ROW_BITS | Row to write |
| wr_hash_i | input | HASH_BITS | Hash to store |
| rd_valid_i | input | 1 | Read request strobe |
| rd_base_row_i | input | ROW_BITS | Row inside the group to read; the low 3 bits are ignored |
| rd_valid_o | output | 1 | Read result valid, one cycle after the request |
| rd_row_ids_o | output | LANES*ROW_BITS | Packed row number of each lane |
| rd_hashes_o | output | LANES*HASH_BITS | Packed hash of each lane |
| rd_lane_valid_o | output | LANES | Per-lane flag: the row has been written since reset |

## Verification
A write and a group read can be sampled on the same edge, and they can hit the same row. The bench provokes this by driving both ports in one cycle.

In the first case it writes a row that already holds a hash while reading its group. The result must show the old hash, and a second read must show the new one. In the second case it writes a row that was never written while reading its group. That lane's flag must read 0 and then 1 on the next read.

// File: rtl/hash_store_pkg.sv
package hash_store_pkg;
  // ceiling log2, at least 1 so vectors never get zero width
  function automatic int unsigned log2_ceil(input int unsigned n);
    int unsigned r;
    r = 1;
    while ((1 << r) < n) r++;
    return r;
  endfunction
endpackage

// File: rtl/hash_store_bank.sv
module hash_store_bank #(
  parameter int unsigned ADDR_BITS = 3,
  parameter int unsigned HASH_BITS = 32,
  localparam int unsigned DEPTH = 1 << ADDR_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_BITS-1:0] waddr_i,
  input  logic [HASH_BITS-1:0] wdata_i,
  input  logic                 re_i,
  input  logic [ADDR_BITS-1:0] raddr_i,
  output logic [HASH_BITS-1:0] rdata_o,
  output logic                 rwritten_o
);
  logic [HASH_BITS-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]     written_q;

  // data array, no reset; nonblocking read gives old data on a same-cycle hit
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q  <= '0;
      rwritten_o <= 1'b0;
    end else begin
      if (we_i) written_q[waddr_i] <= 1'b1;
      if (re_i) rwritten_o <= written_q[raddr_i];
    end
  end

  AST_WRITE_MARKS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> written_q[$past(waddr_i)]); // R6
endmodule

// File: rtl/hash_store_wr_dec.sv
module hash_store_wr_dec #(
  parameter int unsigned LANES    = 8,
  parameter int unsigned ROW_BITS = 6,
  localparam int unsigned LANE_BITS = hash_store_pkg::log2_ceil(LANES),
  localparam int unsigned ADDR_BITS = ROW_BITS - LANE_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [ROW_BITS-1:0]  wr_row_i,
  output logic [LANES-1:0]     bank_we_o,
  output logic [ADDR_BITS-1:0] bank_addr_o
);
  assign bank_addr_o = wr_row_i[ROW_BITS-1:LANE_BITS];

  for (genvar b = 0; b < LANES; b++) begin : g_sel
    assign bank_we_o[b] = wr_valid_i && (wr_row_i[LANE_BITS-1:0] == LANE_BITS'(b));
  end

  AST_WE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we_o)); // R5
  AST_WE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> (bank_we_o == '0)); // R5
endmodule

// File: rtl/hash_store_rd_stage.sv
module hash_store_rd_stage #(
  parameter int unsigned LANES    = 8,
  parameter int unsigned ROW_BITS = 6,
  localparam int unsigned LANE_BITS = hash_store_pkg::log2_ceil(LANES),
  localparam int unsigned ADDR_BITS = ROW_BITS - LANE_BITS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_valid_i,
  input  logic [ADDR_BITS-1:0]      group_i,
  output logic                      rd_valid_o,
  output logic [LANES*ROW_BITS-1:0] row_ids_o
);
  logic [ADDR_BITS-1:0] group_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      group_q    <= '0;
    end else begin
      rd_valid_o <= rd_valid_i;
      if (rd_valid_i) group_q <= group_i;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_id
    assign row_ids_o[k*ROW_BITS +: ROW_BITS] = {group_q, LANE_BITS'(k)};
  end

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_valid_o); // R2
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !rd_valid_o); // R2
  AST_LANE0_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (row_ids_o[LANE_BITS-1:0] == '0)); // R10
endmodule

// File: rtl/hash_store_banked.sv
module hash_store_banked #(
  parameter int unsigned LANES     = 8,
  parameter int unsigned ROW_BITS  = 6,
  parameter int unsigned HASH_BITS = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_valid_i,
  input  logic [ROW_BITS-1:0]        wr_row_i,
  input  logic [HASH_BITS-1:0]       wr_hash_i,
  input  logic                       rd_valid_i,
  input  logic [ROW_BITS-1:0]        rd_base_row_i,
  output logic                       rd_valid_o,
  output logic [LANES*ROW_BITS-1:0]  rd_row_ids_o,
  output logic [LANES*HASH_BITS-1:0] rd_hashes_o,
  output logic [LANES-1:0]           rd_lane_valid_o
);
  localparam int unsigned LANE_BITS = hash_store_pkg::log2_ceil(LANES);
  localparam int unsigned ADDR_BITS = ROW_BITS - LANE_BITS;

  logic [LANES-1:0]     bank_we;
  logic [ADDR_BITS-1:0] bank_waddr;
  logic [ADDR_BITS-1:0] rd_group;

  // low bits of the base pick a lane, so they are dropped here
  assign rd_group = rd_base_row_i[ROW_BITS-1:LANE_BITS];

  hash_store_wr_dec #(.LANES(LANES), .ROW_BITS(ROW_BITS)) u_wr_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_row_i    (wr_row_i),
    .bank_we_o   (bank_we),
    .bank_addr_o (bank_waddr)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    hash_store_bank #(.ADDR_BITS(ADDR_BITS), .HASH_BITS(HASH_BITS)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (bank_we[b]),
      .waddr_i    (bank_waddr),
      .wdata_i    (wr_hash_i),
      .re_i       (rd_valid_i),
      .raddr_i    (rd_group),
      .rdata_o    (rd_hashes_o[b*HASH_BITS +: HASH_BITS]),
      .rwritten_o (rd_lane_valid_o[b])
    );
  end

  hash_store_rd_stage #(.LANES(LANES), .ROW_BITS(ROW_BITS)) u_rd_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_valid_i (rd_valid_i),
    .group_i    (rd_group),
    .rd_valid_o (rd_valid_o),
    .row_ids_o  (rd_row_ids_o)
  );

  AST_WR_BANK_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> bank_we[wr_row_i[LANE_BITS-1:0]]); // R7
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> $stable(rd_lane_valid_o)); // R11
  AST_IDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> $stable(rd_row_ids_o)); // R11
endmodule

// File: tb/hash_store_banked_bench.sv
module hash_store_banked_bench;
  localparam int LANES = 8;
  localparam int RB    = 6;
  localparam int HB    = 32;
  localparam int ROWS  = 1 << RB;

  typedef struct packed {
    logic [RB-1:0] row;
    logic [HB-1:0] hash;
  } wr_vec_t;

  // write vectors; row 3 is written twice, rows 3/11/19 share a bank
  localparam wr_vec_t WR_TAB [12] = '{
    '{6'd0,  32'hA000_0000}, '{6'd1,  32'hA111_1111}, '{6'd7,  32'hA777_7777},
    '{6'd3,  32'hA333_3333}, '{6'd11, 32'hB111_0011}, '{6'd19, 32'hC019_0019},
    '{6'd8,  32'hB000_0008}, '{6'd15, 32'hB015_0015}, '{6'd63, 32'hF063_0063},
    '{6'd56, 32'hF056_0056}, '{6'd3,  32'hD333_0003}, '{6'd40, 32'hE040_0040}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [RB-1:0] wr_row = '0;
  logic [HB-1:0] wr_hash = '0;
  logic rd_valid = 1'b0;
  logic [RB-1:0] rd_base = '0;
  logic rd_valid_o;
  logic [LANES*RB-1:0] rd_ids;
  logic [LANES*HB-1:0] rd_hashes;
  logic [LANES-1:0] rd_mask;

  logic [HB-1:0] mdl_hash [ROWS];
  bit            mdl_wr   [ROWS];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hash_store_banked #(.LANES(LANES), .ROW_BITS(RB), .HASH_BITS(HB)) u_hash_store_banked (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_row_i(wr_row), .wr_hash_i(wr_hash),
    .rd_valid_i(rd_valid), .rd_base_row_i(rd_base),
    .rd_valid_o(rd_valid_o), .rd_row_ids_o(rd_ids),
    .rd_hashes_o(rd_hashes), .rd_lane_valid_o(rd_mask)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mdl_clear();
    for (int r = 0; r < ROWS; r++) mdl_wr[r] = 0;
  endtask

  task automatic write_row(input logic [RB-1:0] row, input logic [HB-1:0] h);
    @(negedge clk);
    wr_valid = 1'b1; wr_row = row; wr_hash = h;
    @(posedge clk);
    mdl_hash[row] = h; mdl_wr[row] = 1;
  endtask

  // outputs are checked at the negedge after the sampling edge
  task automatic read_check(input logic [RB-1:0] base_in, input string tag);
    int base;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_valid = 1'b1; rd_base = base_in;
    @(negedge clk);
    rd_valid = 1'b0;
    base = int'(base_in) & ~(LANES - 1);
    chk({tag, " R2 valid"}, 64'(rd_valid_o), 64'd1);
    for (int k = 0; k < LANES; k++) begin
      chk({tag, " R3 R1 R10 row id"}, 64'(rd_ids[k*RB +: RB]), 64'(base + k));
      chk({tag, " R6 mask"}, 64'(rd_mask[k]), 64'(mdl_wr[base + k]));
      if (mdl_wr[base + k])
        chk({tag, " R4 R5 R7 hash"}, 64'(rd_hashes[k*HB +: HB]), 64'(mdl_hash[base + k]));
    end
  endtask

  initial begin
    logic [LANES*HB-1:0] hold_h;
    logic [LANES*RB-1:0] hold_id;
    logic [LANES-1:0]    hold_m;
    mdl_clear();
    repeat (3) @(negedge clk);
    chk("R8 reset valid", 64'(rd_valid_o), 64'd0);
    chk("R8 reset mask", 64'(rd_mask), 64'd0);
    rst_n = 1'b1;

    read_check(6'd0, "empty");

    // table walk: back-to-back writes
    for (int i = 0; i < 12; i++) write_row(WR_TAB[i].row, WR_TAB[i].hash);
    for (int g = 0; g < ROWS / LANES; g++)
      read_check(6'(g * LANES + (g % LANES)), "group");

    // R2 pulse ends; R11 outputs hold under a write
    hold_h = rd_hashes; hold_id = rd_ids; hold_m = rd_mask;
    write_row(6'd57, 32'h5757_5757);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R2 valid drops", 64'(rd_valid_o), 64'd0);
    chk("R11 ids hold", 64'(rd_ids), 64'(hold_id));
    chk("R11 mask hold", 64'(rd_mask), 64'(hold_m));
    n_chk++;
    if (rd_hashes !== hold_h) begin
      n_fail++;
      $display("FAIL R11 hashes hold: actual %0h expected %0h", rd_hashes, hold_h);
    end

    // R9 same-cycle write and read of a written row
    @(negedge clk);
    wr_valid = 1'b1; wr_row = 6'd19; wr_hash = 32'h9999_0019;
    rd_valid = 1'b1; rd_base = 6'd16;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    chk("R9 old hash", 64'(rd_hashes[3*HB +: HB]), 64'h C019_0019);
    chk("R9 old mask", 64'(rd_mask[3]), 64'd1);
    mdl_hash[19] = 32'h9999_0019;
    read_check(6'd16, "R9 after");

    // R9 same-cycle write and read of an unwritten row
    @(negedge clk);
    wr_valid = 1'b1; wr_row = 6'd20; wr_hash = 32'h2020_2020;
    rd_valid = 1'b1; rd_base = 6'd23;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    chk("R9 unwritten flag old", 64'(rd_mask[4]), 64'd0);
    mdl_hash[20] = 32'h2020_2020; mdl_wr[20] = 1;
    read_check(6'd16, "R9 flag new");

    // R8 reset mid-run forgets written rows
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 mid reset valid", 64'(rd_valid_o), 64'd0);
    chk("R8 mid reset mask", 64'(rd_mask), 64'd0);
    rst_n = 1'b1;
    mdl_clear();
    read_check(6'd0, "R8 after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule